// File: doc/BRIEF.md
# Serial Chain Wiper Register Loader

This block is the receive side of a three-wire serial port that sets an 8-bit wiper code. A host lowers an active-low select line, clocks data bits in most significant first on the rising edges of a serial clock, and then raises the select line. The rising select copies the shift register into the wiper register. Everything runs on one system clock. The three serial inputs pass through synchronizer flops and edge detectors before the design uses them.

The serial output is open-drain, so the block only drives a pull-low enable. During a frame this output carries the register's top bit, updated after each falling serial-clock edge. Several units can therefore share select and clock and pass data from one unit's output to the next unit's input. In a 16-bit frame sent to two chained units, the first byte ends up in the far unit and the second byte stays in the near one. Both units commit on the same select release.

Top module: `spi_chain_wiper_loader`

## Requirements
- R1: After reset the wiper register reads 0x80, the shift register holds zero (a select pulse with no clocks then commits 0x00), and the pull-low enable is inactive.
- R2: While select is low, each rising serial-clock edge shifts the data input into bit 0 and moves the older bits toward bit 7. An 8-bit frame sent most significant bit first therefore lands in the wiper register unchanged.
- R3: The wiper register changes only when select rises. It holds its value through a whole frame and takes the new word within SYNC_STAGES+2 system cycles of the select release.
- R4: When more than 8 bits are clocked in one select-low period, only the last 8 bits are kept. The earlier bits drop out of the top.
- R5: When fewer than 8 bits are clocked, including none, the commit still copies the whole shift register. The word keeps older bits left over from earlier frames.
- R6: Serial-clock edges while select is high change neither the shift register nor the pull-low enable.
- R7: During a frame, once a falling serial-clock edge has been seen, the pull-low enable equals the inverse of shift-register bit 7. While select is high the enable is inactive, so the line is released.
- R8: With two units chained through the serial output and a 16-bit frame, the far unit commits the first 8 bits and the near unit commits the last 8 bits, on the same select release.
- R9: A rising serial-clock edge that reaches the logic in the same system cycle as the select release is still shifted in. The committed word includes that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low frame select |
| ser_clk | input | 1 | Serial clock, sampled on its rising edge |
| ser_din | input | 1 | Serial data input |
| chain_pull_low | output | 1 | Open-drain serial output: 1 pulls the line low |
| wiper_code | output | WORD_W | Committed wiper register |

## Verification
Two events can land in the same system cycle: the last rising serial-clock edge of a frame and the select release. The bench provokes this by raising both inputs on the same system-clock edge. They then pass through identical synchronizers and are detected together. The committed word is then compared with the model word that includes the final bit, in both the near and the far unit. If that edge were dropped, the expected byte would be wrong in at least one unit.

// File: rtl/spi_wl_pkg.sv
package spi_wl_pkg;
  localparam int DEF_WORD_W = 8;
  localparam int DEF_SYNC   = 2;
  localparam int LANES      = 3;

  typedef enum int unsigned {
    LANE_SCLK = 0,
    LANE_SELN = 1,
    LANE_SDIN = 2
  } lane_e;

  // Value held by each synchronizer lane at reset: clock low, select high, data high.
  localparam logic [LANES-1:0] LANE_IDLE = 3'b110;
endpackage

// File: rtl/spi_wl_sync.sv
module spi_wl_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe <= {STAGES{IDLE[g]}};
      end else begin
        pipe[0] <= raw[g];
        for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
      end
    end
    assign lvl[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/spi_wl_edge.sv
module spi_wl_edge #(
  parameter int N = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] prev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= lvl;
  end
endmodule

// File: rtl/spi_wl_shifter.sv
module spi_wl_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_fire,
  input  logic         bit_in,
  output logic [W-1:0] word_q,
  output logic [W-1:0] word_nx
);
  function automatic logic [W-1:0] push_bit(input logic [W-1:0] w, input logic b);
    return {w[W-2:0], b};
  endfunction

  assign word_nx = shift_fire ? push_bit(word_q, bit_in) : word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_nx;
  end

  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> word_q[0] == $past(bit_in)); // R2
  AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_fire |=> $stable(word_q)); // R6
endmodule

// File: rtl/spi_wl_commit.sv
module spi_wl_commit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit_fire,
  input  logic [W-1:0] word_nx,
  output logic [W-1:0] wiper
);
  function automatic logic [W-1:0] midscale();
    return {1'b1, {(W-1){1'b0}}};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wiper <= midscale();
    else if (commit_fire) wiper <= word_nx;
  end

  AST_WIPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(wiper)); // R3
  AST_WIPER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> wiper == $past(word_nx)); // R9
endmodule

// File: rtl/spi_wl_chain_out.sv
module spi_wl_chain_out (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_active,
  input  logic fall_fire,
  input  logic top_bit,
  output logic pull_low
);
  logic line_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          line_bit <= 1'b1;
    else if (!sel_active) line_bit <= 1'b1;
    else if (fall_fire)  line_bit <= top_bit;
  end

  assign pull_low = ~line_bit;

  AST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_active |=> !pull_low); // R7
  AST_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_active && !fall_fire) |=> $stable(pull_low)); // R7
endmodule

// File: rtl/spi_chain_wiper_loader.sv
module spi_chain_wiper_loader
  import spi_wl_pkg::*;
#(
  parameter int WORD_W = DEF_WORD_W,
  parameter int SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              chain_pull_low,
  output logic [WORD_W-1:0] wiper_code
);
  localparam logic [1:0] EDGE_IDLE = {LANE_IDLE[LANE_SELN], LANE_IDLE[LANE_SCLK]};

  logic [LANES-1:0] raw_in, lvl;
  logic [1:0]       edge_lvl, edge_prev;
  logic             sclk_rise, sclk_fall, sel_rise, sel_active;
  logic             shift_fire, commit_fire, fall_fire;
  logic [WORD_W-1:0] word_q, word_nx;

  always_comb begin
    raw_in = '0;
    raw_in[LANE_SCLK] = ser_clk;
    raw_in[LANE_SELN] = sel_n;
    raw_in[LANE_SDIN] = ser_din;
  end

  spi_wl_sync #(.N(LANES), .STAGES(SYNC_STAGES), .IDLE(LANE_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(raw_in), .lvl(lvl));

  assign edge_lvl = {lvl[LANE_SELN], lvl[LANE_SCLK]};

  spi_wl_edge #(.N(2), .IDLE(EDGE_IDLE)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(edge_lvl), .prev(edge_prev));

  // Named events; select is judged by its value before this cycle's change.
  assign sclk_rise   = edge_lvl[0] & ~edge_prev[0];
  assign sclk_fall   = ~edge_lvl[0] & edge_prev[0];
  assign sel_rise    = edge_lvl[1] & ~edge_prev[1];
  assign sel_active  = ~edge_prev[1];
  assign shift_fire  = sclk_rise & sel_active;
  assign fall_fire   = sclk_fall & sel_active;
  assign commit_fire = sel_rise;

  spi_wl_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_fire(shift_fire), .bit_in(lvl[LANE_SDIN]),
    .word_q(word_q), .word_nx(word_nx));

  spi_wl_commit #(.W(WORD_W)) u_commit (
    .clk(clk), .rst_n(rst_n), .commit_fire(commit_fire), .word_nx(word_nx),
    .wiper(wiper_code));

  spi_wl_chain_out u_chain (
    .clk(clk), .rst_n(rst_n), .sel_active(sel_active), .fall_fire(fall_fire),
    .top_bit(word_q[WORD_W-1]), .pull_low(chain_pull_low));

  AST_SHIFT_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_prev[1] && edge_lvl[1]) |=> $stable(word_q)); // R6
endmodule

// File: tb/test_spi_chain_wiper_loader.sv
module test_spi_chain_wiper_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 8;

  logic clk = 0, rst_n = 0;
  logic sel_n = 1, ser_clk = 0, ser_din = 1;
  logic near_pl, far_pl;
  logic [7:0] near_w, far_w;
  int total = 0, bad = 0;
  logic [7:0] near_m = 8'h00, far_m = 8'h00;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_chain_wiper_loader i_spi_chain_wiper_loader (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .chain_pull_low(near_pl), .wiper_code(near_w));

  spi_chain_wiper_loader i_far (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .ser_din(~near_pl),
    .chain_pull_low(far_pl), .wiper_code(far_w));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] push(input logic [7:0] w, input logic b);
    return {w[6:0], b};
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends n bits, bits[n-1] first; if coincide, the last rising edge comes with the select release.
  task automatic frame(input int n, input logic [31:0] bits, input bit coincide);
    logic [7:0] old_near = near_w;
    string tag;
    sel_n = 0;
    wait_n(HP);
    for (int k = 0; k < n; k++) begin
      logic b = bits[n-1-k];
      logic far_in = (k == 0) ? 1'b1 : near_m[7];
      ser_din = b;
      wait_n(HP);
      if (coincide && k == n-1) begin
        check("R3 hold before release", near_w, old_near);
        far_m = push(far_m, far_in);
        near_m = push(near_m, b);
        ser_clk = 1; sel_n = 1;
        wait_n(HP);
        ser_clk = 0;
      end else begin
        ser_clk = 1;
        far_m = push(far_m, far_in);
        near_m = push(near_m, b);
        wait_n(HP);
        ser_clk = 0;
        wait_n(5);
        check("R7 chain bit", near_pl, !near_m[7]);
      end
    end
    if (!(coincide && n > 0)) begin
      wait_n(HP);
      check("R3 hold before release", near_w, old_near);
      sel_n = 1;
    end
    wait_n(6);
    if (coincide) tag = "R9 coincident commit";
    else if (n == 8) tag = "R2 byte load";
    else if (n > 8) tag = "R4 last eight kept";
    else tag = "R5 short frame";
    check(tag, near_w, near_m);
    check("R8 far unit", far_w, far_m);
    check("R7 released", near_pl, 0);
  endtask

  task automatic idle_toggles(input int cnt);
    for (int k = 0; k < cnt; k++) begin
      ser_din = 1'($urandom_range(0, 1));
      wait_n(HP); ser_clk = 1;
      wait_n(HP); ser_clk = 0;
      check("R6 no pull while idle", near_pl, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    wait_n(4);
    rst_n = 1;
    wait_n(2);
    check("R1 reset wiper", near_w, 8'h80);
    check("R1 reset far wiper", far_w, 8'h80);
    check("R1 reset line", near_pl, 0);
    frame(0, 0, 0);                        // R1: cleared shift register committed
    frame(8, 32'hA5, 0);                   // R2
    frame(16, 32'h3CC3, 0);                // R8: far 0x3C, near 0xC3
    check("R8 directed far", far_w, 8'h3C);
    check("R8 directed near", near_w, 8'hC3);
    frame(12, 32'h5E1, 0);                 // R4
    frame(3, 32'h5, 0);                    // R5
    idle_toggles(6);                       // R6
    frame(0, 0, 0);                        // R6: contents unchanged by idle edges
    frame(8, 32'h6B, 1);                   // R9
    frame(16, 32'h81FE, 1);                // R9 with chain
    for (int f = 0; f < 40; f++) begin
      int n = $urandom_range(0, 20);
      if ($urandom_range(0, 3) == 0) idle_toggles($urandom_range(1, 3));
      frame(n, $urandom, (n > 0) && ($urandom_range(0, 4) == 0));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule